// File: doc/BRIEF.md
# Tamper-Erasable Backup Register Bank

This block is a bank of ten 16-bit general-purpose storage words that live in a battery-backed domain. Software reaches them through a plain address/data bus with byte offsets. Their job is to keep a small amount of state that must outlive the rest of the chip.

The bank has its own active-low asynchronous reset, `rst_ni`, which stands for the backup-domain reset. It also has a system reset input, `sys_rst_ni`, which it deliberately ignores. Ordinary resets, power cycling of the core and standby exits therefore leave the stored words intact.

A tamper event wipes every word in a single clock, but only while the tamper function is enabled. A qualified tamper event also sets a sticky flag. Software can read that flag and clear it at the control offset.

Top module: `bkp_reg_bank`

## Requirements
- R1: Ten data words, numbered 1 to 10, sit at byte offsets 4·n (04h, 08h, … 28h). Each word holds all 16 bits, and every bit is readable and writable.
- R2: While `rst_ni` is low, asynchronously and without any clock, every data word reads 0000h and the tamper flag reads 0.
- R3: `sys_rst_ni` has no effect on the data words or the tamper flag.
- R4: When `tamper_evt_i` and `tamper_en_i` are both high at a rising clock edge, all ten words read 0000h after that edge.
- R5: When `tamper_evt_i` is high while `tamper_en_i` is low, the data words and the tamper flag keep their values.
- R6: If an enabled tamper event and a bus write to a data word fall on the same edge, the erase wins and the word reads 0000h.
- R7: An offset that is neither 00h nor a data-word offset reads 0000h, and a write to it changes no state. Unmapped offsets include any offset with `addr_i[1:0]` not equal to 00 and any offset from 2Ch upward.
- R8: Offset 00h holds the tamper flag in bit 0; bits 15:1 read 0. The flag is set by an enabled tamper event. A write to 00h with `wdata_i[0]=1` clears it, and a write with `wdata_i[0]=0` leaves it unchanged. If a set and a clear fall on the same edge, the set wins.
- R9: A write happens at the rising edge where `sel_i` and `we_i` are both high. Reads are combinational from `addr_i` and reflect the value stored by the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Backup-domain clock |
| rst_ni | input | 1 | Backup-domain reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low; ignored by the bank |
| sel_i | input | 1 | Bus access select |
| we_i | input | 1 | Write enable, qualified by `sel_i` |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| tamper_evt_i | input | 1 | Filtered tamper event, sampled at the clock edge |
| tamper_en_i | input | 1 | Tamper function enable |

## Verification
The assertions assume three things about the inputs:
- every input is synchronous to `clk_i`;
- `tamper_evt_i` has already been filtered, so its level at an edge is the event;
- `addr_i` and `wdata_i` are stable across the edge at which a write is taken.

The stimulus keeps within these assumptions by changing all inputs only on falling edges and holding them through the next rising edge. It samples `rdata_o` shortly after a falling edge, never at the capturing edge. Tamper pulses last exactly one clock.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  localparam int unsigned NUM_WORDS_DEF = 10;
  localparam int unsigned DATA_W_DEF    = 16;
  localparam int unsigned ADDR_W_DEF    = 6;
  localparam int unsigned FLAG_OFFSET   = 0;

  // byte offset of data word n (n starts at 1)
  function automatic int unsigned word_offset(input int unsigned n);
    return n * 4;
  endfunction
endpackage

// File: rtl/bkp_addr_dec.sv
module bkp_addr_dec #(
  parameter int unsigned NUM_WORDS = bkp_pkg::NUM_WORDS_DEF,
  parameter int unsigned ADDR_W    = bkp_pkg::ADDR_W_DEF
) (
  input  logic                 sel_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_WORDS-1:0] word_hit_o,
  output logic [NUM_WORDS-1:0] word_we_o,
  output logic                 flag_hit_o,
  output logic                 flag_we_o
);
  logic bus_wr;
  assign bus_wr     = sel_i & we_i;
  assign flag_hit_o = (addr_i == ADDR_W'(bkp_pkg::FLAG_OFFSET));
  assign flag_we_o  = bus_wr & flag_hit_o;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word_dec
    assign word_hit_o[i] = (addr_i == ADDR_W'(bkp_pkg::word_offset(i + 1)));
    assign word_we_o[i]  = bus_wr & word_hit_o[i];
  end
endmodule

// File: rtl/bkp_word.sv
module bkp_word #(
  parameter int unsigned DATA_W = bkp_pkg::DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wipe_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (wipe_i) q_o <= '0;   // erase outranks bus write
    else if (we_i)   q_o <= d_i;
  end

  a_r4_wipe_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> (q_o == '0));
  a_r6_wipe_over_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wipe_i && we_i) |=> (q_o == '0));
  a_r9_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wipe_i) |=> (q_o == $past(d_i)));
  a_r3_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !wipe_i) |=> $stable(q_o));
endmodule

// File: rtl/bkp_tamper_ctl.sv
module bkp_tamper_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tamper_evt_i,
  input  logic tamper_en_i,
  input  logic clr_i,
  output logic wipe_o,
  output logic flag_o
);
  assign wipe_o = tamper_evt_i & tamper_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (wipe_o) flag_o <= 1'b1;   // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  a_r8_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tamper_evt_i && tamper_en_i) |=> flag_o);
  a_r8_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(tamper_evt_i && tamper_en_i)) |=> !flag_o);
  a_r5_disabled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tamper_en_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/bkp_reg_bank.sv
module bkp_reg_bank #(
  parameter int unsigned NUM_WORDS = bkp_pkg::NUM_WORDS_DEF,
  parameter int unsigned DATA_W    = bkp_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W    = bkp_pkg::ADDR_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sys_rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tamper_evt_i,
  input  logic              tamper_en_i
);
  logic [NUM_WORDS-1:0]             word_hit, word_we;
  logic                             flag_hit, flag_we, flag_q, wipe;
  logic [NUM_WORDS-1:0][DATA_W-1:0] word_q;
  logic [DATA_W-1:0]                rd_mux;

  bkp_addr_dec #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_dec (
    .sel_i      (sel_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .word_hit_o (word_hit),
    .word_we_o  (word_we),
    .flag_hit_o (flag_hit),
    .flag_we_o  (flag_we)
  );

  bkp_tamper_ctl u_tamper (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tamper_evt_i (tamper_evt_i),
    .tamper_en_i  (tamper_en_i),
    .clr_i        (flag_we & wdata_i[0]),
    .wipe_o       (wipe),
    .flag_o       (flag_q)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    bkp_word #(.DATA_W(DATA_W)) u_word (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wipe_i (wipe),
      .we_i   (word_we[i]),
      .d_i    (wdata_i),
      .q_o    (word_q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < int'(NUM_WORDS); i++)
      if (word_hit[i]) rd_mux = word_q[i];
    if (flag_hit) rd_mux = DATA_W'(flag_q);
  end
  assign rdata_o = rd_mux;

  // system reset is not a clear source: state only moves on bus write or erase
  a_r3_sys_rst_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_ni && !(sel_i && we_i) && !(tamper_evt_i && tamper_en_i))
      |=> ($stable(word_q) && $stable(flag_q)));
  a_r7_misaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[1:0] != 2'b00) |-> (rdata_o == '0));
  a_r7_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({word_we, flag_we}));
  a_r2_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (word_q == '0 && !flag_q));
endmodule

// File: tb/tb_bkp_reg_bank.sv
module tb_bkp_reg_bank;
  localparam int NW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, sys_rst_n = 1'b1;
  logic        sel = 1'b0, we = 1'b0, evt = 1'b0, ten = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] model [1:NW];
  logic        flag_m;

  always #2.5 clk = ~clk;  // 200 MHz

  bkp_reg_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n),
    .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tamper_evt_i(evt), .tamper_en_i(ten)
  );

  // {we, addr, wdata, expected read}
  localparam logic [38:0] VEC [20] = '{
    {1'b1, 6'h04, 16'hA101, 16'h0000}, {1'b1, 6'h08, 16'h5202, 16'h0000},
    {1'b1, 6'h0C, 16'hC303, 16'h0000}, {1'b1, 6'h10, 16'h3404, 16'h0000},
    {1'b1, 6'h14, 16'hE505, 16'h0000}, {1'b1, 6'h18, 16'h1606, 16'h0000},
    {1'b1, 6'h1C, 16'h9707, 16'h0000}, {1'b1, 6'h20, 16'h6808, 16'h0000},
    {1'b1, 6'h24, 16'hFFFF, 16'h0000}, {1'b1, 6'h28, 16'h8A0A, 16'h0000},
    {1'b0, 6'h04, 16'h0000, 16'hA101}, {1'b0, 6'h08, 16'h0000, 16'h5202},
    {1'b0, 6'h0C, 16'h0000, 16'hC303}, {1'b0, 6'h10, 16'h0000, 16'h3404},
    {1'b0, 6'h14, 16'h0000, 16'hE505}, {1'b0, 6'h18, 16'h0000, 16'h1606},
    {1'b0, 6'h1C, 16'h0000, 16'h9707}, {1'b0, 6'h20, 16'h0000, 16'h6808},
    {1'b0, 6'h24, 16'h0000, 16'hFFFF}, {1'b0, 6'h28, 16'h0000, 16'h8A0A}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle, optionally with a tamper pulse on the same edge
  task automatic cyc(input logic s, input logic w, input logic [5:0] a,
                     input logic [15:0] d, input logic e);
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; evt = e;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; evt = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] v);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 v = rdata;
    sel = 1'b0;
  endtask

  task automatic chk_all(input string req);
    logic [15:0] v;
    for (int n = 1; n <= NW; n++) begin
      rd(6'(n * 4), v);
      chk(req, v, model[n]);
    end
    rd(6'h00, v);
    chk(req, v, {15'b0, flag_m});
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    for (int n = 1; n <= NW; n++) model[n] = 16'h0000;
    flag_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    chk_all("R2");

    // R1, R9 table walk
    foreach (VEC[k]) begin
      if (VEC[k][38]) begin
        cyc(1'b1, 1'b1, VEC[k][37:32], VEC[k][31:16], 1'b0);
        model[VEC[k][37:32] / 4] = VEC[k][31:16];
      end else begin
        rd(VEC[k][37:32], v);
        chk("R1/R9", v, VEC[k][15:0]);
      end
    end

    // R7 unmapped reads and writes
    rd(6'h2C, v); chk("R7", v, 16'h0000);
    rd(6'h06, v); chk("R7", v, 16'h0000);
    rd(6'h3C, v); chk("R7", v, 16'h0000);
    cyc(1'b1, 1'b1, 6'h06, 16'h1234, 1'b0);
    cyc(1'b1, 1'b1, 6'h2C, 16'h4321, 1'b0);
    cyc(1'b1, 1'b1, 6'h3C, 16'h5555, 1'b0);
    rd(6'h2C, v); chk("R7", v, 16'h0000);
    chk_all("R7");

    // R3 system reset does nothing
    @(negedge clk); sys_rst_n = 1'b0;
    repeat (4) @(negedge clk); sys_rst_n = 1'b1;
    chk_all("R3");

    // R5 tamper while disabled
    ten = 1'b0;
    cyc(1'b0, 1'b0, 6'h00, 16'h0000, 1'b1);
    chk_all("R5");

    // R4, R6, R8: enabled tamper on the same edge as a write to word 3
    ten = 1'b1;
    cyc(1'b1, 1'b1, 6'h0C, 16'hBEEF, 1'b1);
    for (int n = 1; n <= NW; n++) model[n] = 16'h0000;
    flag_m = 1'b1;
    rd(6'h0C, v); chk("R6", v, 16'h0000);
    chk_all("R4");
    ten = 1'b0;

    // R8 clear semantics
    cyc(1'b1, 1'b1, 6'h00, 16'hFFFE, 1'b0);
    rd(6'h00, v); chk("R8", v, 16'h0001);
    cyc(1'b1, 1'b1, 6'h00, 16'h0001, 1'b0);
    rd(6'h00, v); chk("R8", v, 16'h0000);
    ten = 1'b1;
    cyc(1'b1, 1'b1, 6'h00, 16'h0001, 1'b1);
    rd(6'h00, v); chk("R8", v, 16'h0001);
    ten = 1'b0;

    // R2 asynchronous backup reset
    cyc(1'b1, 1'b1, 6'h28, 16'h7E7E, 1'b0);
    rd(6'h28, v); chk("R9", v, 16'h7E7E);
    @(negedge clk); #1 rst_n = 1'b0;
    #0.5 addr = 6'h28;
    #0.3 chk("R2", rdata, 16'h0000);
    addr = 6'h00;
    #0.3 chk("R2", rdata, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    for (int n = 1; n <= NW; n++) model[n] = 16'h0000;
    flag_m = 1'b0;
    chk_all("R2");

    done = 1;
    summary();
    $finish;
  end
endmodule